// File: doc/BRIEF.md
# Break-Frozen Two-Step Status Flags

This block holds a bank of sticky status flags. Hardware events set the flags. Software clears them in two steps. The first step reads the status register while a flag is set, which arms a hidden pending-clear bit for that flag. The second step is any later access to the data register, and it clears every armed flag. Flags that are set after the status read are therefore never lost: a flag is cleared only if software has seen it.

A global debug-break input lets a debugger inspect registers without side effects. While the break is active and the clear-enable control bit is 0, status reads arm nothing and data accesses clear nothing. A flag armed before the break stays armed through it, so the second step can still be completed after the break. If software writes the control bit to 1, the two-step clear works normally during the break, and a flag cleared then stays cleared once the break ends. Hardware set events always act, with or without a break.

Top module: `sfp_status_bank`

## Requirements
- R1: After reset every flag output reads 0.
- R2: A 1 on bit i of `set_evt` makes `flags[i]` read 1 from the next clock. The flag then holds 1 until it is cleared by the two-step sequence.
- R3: A `stat_rd` pulse taken while `flags[i]` is 1 arms flag i. A later `data_acc` pulse clears every armed flag from the next clock. A `data_acc` pulse with no earlier arming read leaves the flags unchanged.
- R4: A `stat_rd` pulse taken while `flags[i]` is 0 does not arm flag i. If the flag is set afterwards, a `data_acc` pulse does not clear it.
- R5: When `set_evt[i]` and a clearing `data_acc` fall in the same cycle, `flags[i]` stays 1 and the arming of flag i is dropped. A further `data_acc` without a new status read leaves the flag at 1.
- R6: While `brk_act` is 1 and the clear-enable bit is 0, `stat_rd` and `data_acc` change no flag and arm nothing. Flags armed before the break stay armed, and a `data_acc` after the break clears them.
- R7: While `brk_act` is 1 and the clear-enable bit is 1, the two-step clear works as in R3. A flag cleared this way stays 0 after `brk_act` returns to 0.
- R8: The clear-enable bit resets to 0. A cycle with `cfg_we` at 1 loads it from `cfg_val`, and `clr_en` shows it from the next clock.
- R9: Set events act during a break whatever the value of the clear-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_evt | input | NFLAGS | Hardware set event per flag |
| stat_rd | input | 1 | Status register read strobe (first step) |
| data_acc | input | 1 | Data register access strobe (second step) |
| brk_act | input | 1 | Debug break state active |
| cfg_we | input | 1 | Write strobe for the clear-enable bit |
| cfg_val | input | 1 | Value written to the clear-enable bit |
| clr_en | output | 1 | Clear-enable bit: clearing is allowed during a break |
| flags | output | NFLAGS | Status flag outputs |

## Verification
Two actions can fall in the same cycle: a hardware set event and the clearing data access on the same flag. A set can also coincide with an arming status read. The directed part forces the set-and-clear collision on an armed flag and then issues a second access with no new read, to show that the arming was dropped. The random part drives sets, reads, accesses, break and configuration writes independently, so the collisions also occur with and without a break. The flags are compared on every cycle with a bench model, in which a set has priority and a clear consumes the arming.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  // Clearing steps are honoured outside a break, or inside one when enabled.
  function automatic logic clear_allowed(input logic brk, input logic en);
    return !brk || en;
  endfunction

  // Next flag value: set has priority over clear.
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set || (cur && !clr);
  endfunction
endpackage

// File: rtl/sfp_ctrl.sv
module sfp_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_val,
  input  logic brk_act,
  output logic clr_en_o,
  output logic allow_o
);
  import sfp_pkg::*;

  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (cfg_we) en_q <= cfg_val;
  end

  assign clr_en_o = en_q;
  assign allow_o  = clear_allowed(brk_act, en_q);

  // R8: a configuration write lands on the next clock
  a_r8_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (clr_en_o == $past(cfg_val)));
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(clr_en_o));
endmodule

// File: rtl/sfp_flag_cell.sv
module sfp_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  input  logic set_evt,
  input  logic stat_rd,
  input  logic data_acc,
  output logic flag_o
);
  import sfp_pkg::*;

  logic flag_q;
  logic armed_q;
  logic arm_go;
  logic clear_go;

  // Named internal events for the assertions.
  assign arm_go   = allow && stat_rd && flag_q;
  assign clear_go = allow && data_acc && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_next(flag_q, set_evt, clear_go);
      armed_q <= !clear_go && (armed_q || arm_go);
    end
  end

  assign flag_o = flag_q;

  // R2: a set event always lands
  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_o);
  // R3: an armed access clears when no set collides
  a_r3_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_go && !set_evt) |=> !flag_o);
  // R5: a collision drops the arming
  a_r5_drop_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_go && set_evt) |=> (flag_o && !armed_q));
  // R6: frozen steps leave flag and arming untouched
  a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!allow && !set_evt) |=> ($stable(flag_o) && $stable(armed_q)));
  // R4: arming only exists on a set flag
  a_r4_arm_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> flag_q);
endmodule

// File: rtl/sfp_status_bank.sv
module sfp_status_bank #(
  parameter int NFLAGS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAGS-1:0] set_evt,
  input  logic              stat_rd,
  input  logic              data_acc,
  input  logic              brk_act,
  input  logic              cfg_we,
  input  logic              cfg_val,
  output logic              clr_en,
  output logic [NFLAGS-1:0] flags
);
  logic allow;

  sfp_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_val  (cfg_val),
    .brk_act  (brk_act),
    .clr_en_o (clr_en),
    .allow_o  (allow)
  );

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    sfp_flag_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .allow    (allow),
      .set_evt  (set_evt[i]),
      .stat_rd  (stat_rd),
      .data_acc (data_acc),
      .flag_o   (flags[i])
    );
  end

  // R1: flags are clear right after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (flags == '0));
  // R9: set events act even during a break
  a_r9_set_in_break: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_act && (set_evt != '0)) |=> ((flags & $past(set_evt)) == $past(set_evt)));
endmodule

// File: tb/sfp_status_bank_test.sv
module sfp_status_bank_test;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] set_evt = '0;
  logic         stat_rd = 1'b0, data_acc = 1'b0, brk_act = 1'b0;
  logic         cfg_we = 1'b0, cfg_val = 1'b0;
  logic         clr_en;
  logic [N-1:0] flags;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [N-1:0] m_flag = '0;
  logic [N-1:0] m_arm = '0;
  logic         m_en = 1'b0;

  always #10 clk = ~clk;

  sfp_status_bank #(.NFLAGS(N)) uut (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .stat_rd(stat_rd),
    .data_acc(data_acc), .brk_act(brk_act), .cfg_we(cfg_we),
    .cfg_val(cfg_val), .clr_en(clr_en), .flags(flags)
  );

  function automatic logic steps_live(logic brk, logic en);
    if (brk) return en;
    return 1'b1;
  endfunction

  task automatic check(string tag, logic [N-1:0] exp_f, logic exp_e);
    checks++;
    if (flags !== exp_f || clr_en !== exp_e) begin
      errors++;
      $display("FAIL %s: flags=%b clr_en=%b expected flags=%b clr_en=%b",
               tag, flags, clr_en, exp_f, exp_e);
    end
  endtask

  // Drive one cycle at the falling edge, advance the model, compare at the next falling edge.
  task automatic step(string tag, logic [N-1:0] s, logic rd, logic acc,
                      logic brk, logic we, logic val);
    logic live;
    logic [N-1:0] nf, na;
    set_evt = s; stat_rd = rd; data_acc = acc; brk_act = brk;
    cfg_we = we; cfg_val = val;
    live = steps_live(brk, m_en);
    for (int i = 0; i < N; i++) begin
      logic clr, arm;
      clr = live && acc && m_arm[i];
      arm = live && rd && m_flag[i];
      if (s[i])        nf[i] = 1'b1;
      else if (clr)    nf[i] = 1'b0;
      else             nf[i] = m_flag[i];
      if (clr)         na[i] = 1'b0;
      else             na[i] = m_arm[i] | arm;
    end
    @(negedge clk);
    m_flag = nf; m_arm = na;
    if (we) m_en = val;
    check(tag, m_flag, m_en);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1", '0, 1'b0);        // R1 and R8 reset values
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", '0, 1'b0);

    // R2: set and hold
    step("R2", 6'b000001, 0, 0, 0, 0, 0);
    step("R2", '0, 0, 0, 0, 0, 0);
    // R3: access without read does nothing, then read and access
    step("R3", '0, 0, 1, 0, 0, 0);
    step("R3", '0, 1, 0, 0, 0, 0);
    step("R3", '0, 0, 1, 0, 0, 0);
    check("R3", 6'b000000, 1'b0);
    // R4: read on a clear flag arms nothing
    step("R4", '0, 1, 0, 0, 0, 0);
    step("R4", 6'b000010, 0, 0, 0, 0, 0);
    step("R4", '0, 0, 1, 0, 0, 0);
    check("R4", 6'b000010, 1'b0);
    // R5: set collides with clearing access
    step("R5", 6'b000100, 1, 0, 0, 0, 0);   // bits 1,2 set; read arms bit1 only
    step("R5", '0, 1, 0, 0, 0, 0);          // arms bits 1 and 2
    step("R5", 6'b000100, 0, 1, 0, 0, 0);
    check("R5", 6'b000100, 1'b0);
    step("R5", '0, 0, 1, 0, 0, 0);
    check("R5", 6'b000100, 1'b0);
    // R6: arm bit3 before break, freeze during break
    step("R6", 6'b001000, 0, 0, 0, 0, 0);
    step("R6", '0, 1, 0, 0, 0, 0);          // arms bits 2 and 3
    step("R6", '0, 0, 1, 1, 0, 0);
    step("R6", '0, 1, 0, 1, 0, 0);
    step("R9", 6'b010000, 0, 1, 1, 0, 0);   // R9: set during frozen break
    check("R9", 6'b011100, 1'b0);
    step("R6", '0, 0, 1, 0, 0, 0);          // after break: armed 2,3 cleared, 4 kept
    check("R6", 6'b010000, 1'b0);
    // R7/R8: enable clearing during break
    step("R8", '0, 0, 0, 0, 1, 1);
    check("R8", 6'b010000, 1'b1);
    step("R7", '0, 1, 0, 1, 0, 0);
    step("R7", '0, 0, 1, 1, 0, 0);
    check("R7", 6'b000000, 1'b1);
    step("R7", '0, 0, 0, 0, 0, 0);
    check("R7", 6'b000000, 1'b1);
    step("R8", '0, 0, 0, 0, 1, 0);

    // Random mix, checked against the model every cycle (R3, R5, R6 interplay)
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] s;
      s = (($urandom % 4) == 0) ? N'($urandom) & N'($urandom) : '0;
      step("R3", s, ($urandom % 3) == 0, ($urandom % 3) == 0,
           ($urandom % 8) < 3, ($urandom % 20) == 0, $urandom % 2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule